// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block models the command side of a parallel NOR flash memory. A host issues single-cycle write strobes carrying an address and a data byte. The sequencer watches for the two-cycle unlock prefix and the command byte that follows it. It then starts a timed byte program, a sector erase or a whole-array erase on a small on-chip byte array. The array is held in inferable RAM and starts fully erased (every byte 0xFF).

Progress is visible in two ways. The `ready` output stays low while an operation runs. A host read during that time returns a status byte instead of array data: bit 7 is the complement of the byte's final bit 7, and bit 6 flips on every read. Further features are a two-cycle programming mode that skips the unlock prefix, suspending an erase to reach other sectors, a per-sector lock input, a low-supply lockout and a synchronous hardware reset.

The array is a scaled top-boot layout with nineteen sectors. There are fifteen equal large sectors. The top large-sized region is split into a half-size sector, two eighth-size sectors and a quarter-size sector, in rising address order.

Top module: `nor_cmd_seq`

## Requirements
- R1: After `rst` (synchronous, active high), `ready` is 1 and reads return array data. Any program or erase in progress is abandoned without writing its pending byte, and the two-cycle mode is left.
- R2: A normal program takes four write cycles: 0xAA at unlock address A1, 0x55 at A2, 0xA0 at A1, then the data at the target address. A1 and A2 are 0x555 and 0x2AA cut to the address width (0x155 and 0x2AA by default). `ready` is 0 from the cycle after the fourth write until the byte is stored.
- R3: Programming only clears bits: the stored byte becomes old AND new.
- R4: Unlock followed by 0x20 at A1 enters two-cycle mode, where 0xA0 at any address then the data at the target programs a byte. 0x90 followed by 0x00 (any addresses) leaves the mode.
- R5: While busy, a read returns bit 7 = complement of the data bit 7 being programmed (0 during erase), bit 6 inverted relative to the previous busy read, and bits 5..0 zero. When done, reads return true array data.
- R6: Unlock, 0x80 at A1, unlock, then 0x30 at an address selects that address's sector for erase. Further bare 0x30 writes within ERASE_WAIT cycles of the last one add their sectors. Afterwards, every byte of the selected sectors reads 0xFF and other sectors are unchanged.
- R7: The same setup ending in 0x10 at A1 erases every unprotected sector.
- R8: Erase first drives each selected byte to 0x00 in one pass over the array, then to 0xFF in a second pass.
- R9: Unlock plus 0xB0 at A1 during an erase pass suspends it; `ready` is 1 the cycle after. While suspended, programs outside the selected sectors run and programs inside them are ignored. Unlock plus 0x30 at A1 resumes the erase, which then completes.
- R10: With `prot[s]` = 1, a program aimed at sector s is ignored (`ready` stays 1) and erases leave sector s unchanged.
- R11: Write strobes while `low_vdd` = 1 have no effect.
- R12: A write that does not fit the current sequence returns the decoder to read mode; a later data write is not taken as a program.
- R13: With the default size, sector 16 covers addresses 0x3E0..0x3E7. Erasing it leaves 0x3DF and 0x3E8 unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | One-cycle host write strobe |
| rd_en | input | 1 | One-cycle host read strobe; `rdata` is valid in the following cycle |
| addr | input | LG_BIG+4 | Byte address for reads and writes |
| wdata | input | 8 | Write data / command byte |
| low_vdd | input | 1 | Low-supply detect; blocks writes while high |
| prot | input | 19 | Per-sector lock, bit s locks sector s |
| rdata | output | 8 | Read data or status byte |
| ready | output | 1 | 1 when no program or erase is running |

## Verification
Assertions check on every cycle that a low-supply write leaves the decoder state unchanged and that 0xA0 in two-cycle mode always arms a program. They also check that a program aimed at a locked sector, or at an erasing sector while suspended, is never started. A suspend request must give a ready, suspended engine one cycle later, the last write of the erase pass must end the operation, and every busy read must show zero low status bits. What only the directed scenarios can show is the content of the array afterwards. That covers the AND-only program result, the 0x00 preprogram value seen during a suspend, the exact sector boundaries, collected multi-sector erase, abort by reset, and the status bit 7 and bit 6 values.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  localparam int NSECT = 19;

  typedef enum logic [3:0] {
    E_IDLE, E_PWAIT, E_PWRITE, E_COLLECT, E_PRE, E_ERASE, E_SUSP, E_SPWAIT, E_SPWRITE
  } eng_st_t;

  typedef enum logic [2:0] {
    D_READ, D_UNL1, D_UNL2, D_PDATA, D_ERS1, D_ERS2, D_ERS3, D_BYPX
  } dec_st_t;

  // Scaled top-boot map: 15 equal sectors, then 1/2, 1/8, 1/8, 1/4 of one.
  function automatic logic [4:0] sector_of(input logic [15:0] a, input int unsigned lg);
    int unsigned top;
    int unsigned off;
    int unsigned sz;
    sz  = 32'd1 << lg;
    top = 32'(a) >> lg;
    off = 32'(a) & (sz - 1);
    if (top < 15)                 return 5'(top);
    else if (off < sz / 2)        return 5'd15;
    else if (off < sz / 2 + sz / 8) return 5'd16;
    else if (off < sz / 2 + sz / 4) return 5'd17;
    else                          return 5'd18;
  endfunction

endpackage

// File: rtl/nor_array.sv
module nor_array #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end
endmodule

// File: rtl/nor_cmd_decode.sv
module nor_cmd_decode
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              low_vdd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              cmd_prog,
  output logic              cmd_chip,
  output logic              cmd_sect,
  output logic              cmd_susp,
  output logic              cmd_resume
);
  localparam logic [ADDR_W-1:0] A_FIRST  = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] A_SECOND = ADDR_W'(12'h2AA);

  dec_st_t st, nxt;
  logic    bypass, bypass_n;
  logic    wr_ok;
  logic    at1, at2;

  assign wr_ok = wr_en & ~low_vdd;
  assign at1   = (addr == A_FIRST);
  assign at2   = (addr == A_SECOND);

  always_comb begin
    nxt        = st;
    bypass_n   = bypass;
    cmd_prog   = 1'b0;
    cmd_chip   = 1'b0;
    cmd_sect   = 1'b0;
    cmd_susp   = 1'b0;
    cmd_resume = 1'b0;
    if (wr_ok) begin
      nxt = D_READ;
      case (st)
        D_READ: begin
          if (bypass) begin
            if (wdata == 8'hA0)      nxt = D_PDATA;
            else if (wdata == 8'h90) nxt = D_BYPX;
          end else if (wdata == 8'hAA && at1) begin
            nxt = D_UNL1;
          end
        end
        D_UNL1: if (wdata == 8'h55 && at2) nxt = D_UNL2;
        D_UNL2: begin
          if (at1) begin
            case (wdata)
              8'hA0:   nxt = D_PDATA;
              8'h80:   nxt = D_ERS1;
              8'h20:   bypass_n = 1'b1;
              8'hB0:   cmd_susp = 1'b1;
              8'h30:   cmd_resume = 1'b1;
              default: nxt = D_READ;
            endcase
          end
        end
        D_PDATA: cmd_prog = 1'b1;
        D_ERS1:  if (wdata == 8'hAA && at1) nxt = D_ERS2;
        D_ERS2:  if (wdata == 8'h55 && at2) nxt = D_ERS3;
        D_ERS3: begin
          if (wdata == 8'h10 && at1) cmd_chip = 1'b1;
          else if (wdata == 8'h30)   cmd_sect = 1'b1;
        end
        D_BYPX:  if (wdata == 8'h00) bypass_n = 1'b0;
        default: nxt = D_READ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= D_READ;
      bypass <= 1'b0;
    end else begin
      st     <= nxt;
      bypass <= bypass_n;
    end
  end

  assert_lowvdd_blocks_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && low_vdd) |=> $stable(st));

  assert_bypass_arms_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !low_vdd && bypass && st == D_READ && wdata == 8'hA0) |=> (st == D_PDATA));
endmodule

// File: rtl/nor_engine.sv
module nor_engine
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int LG_BIG     = 6,
  parameter int PROG_WAIT  = 8,
  parameter int ERASE_WAIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              low_vdd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [NSECT-1:0]  prot,
  input  logic              cmd_prog,
  input  logic              cmd_chip,
  input  logic              cmd_sect,
  input  logic              cmd_susp,
  input  logic              cmd_resume,
  input  logic [7:0]        mem_q,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic              eng_rd,
  output logic [ADDR_W-1:0] eng_raddr,
  output logic              busy,
  output logic              ready,
  output logic              stat_d7
);
  localparam int PW = $clog2(PROG_WAIT + 1);
  localparam int EW = $clog2(ERASE_WAIT + 1);
  localparam logic [ADDR_W-1:0] LAST = '1;

  eng_st_t            st, nxt, phase;
  logic [PW-1:0]      pcnt;
  logic [EW-1:0]      ecnt;
  logic [ADDR_W-1:0]  walk, paddr;
  logic [7:0]         pdata;
  logic [NSECT-1:0]   mask, cmd_oh;
  logic [4:0]         cmd_sec, walk_sec;
  logic               wr_ok, add_sect, nxt_busy;

  assign wr_ok    = wr_en & ~low_vdd;
  assign cmd_sec  = sector_of(16'(addr), LG_BIG);
  assign walk_sec = sector_of(16'(walk), LG_BIG);
  assign cmd_oh   = NSECT'(1) << cmd_sec;
  assign add_sect = wr_ok && (wdata == 8'h30);

  always_comb begin
    nxt       = st;
    mem_we    = 1'b0;
    mem_waddr = walk;
    mem_wdata = 8'h00;
    eng_rd    = 1'b0;
    eng_raddr = paddr;
    case (st)
      E_IDLE: begin
        if (cmd_prog && !prot[cmd_sec]) nxt = E_PWAIT;
        else if (cmd_chip || cmd_sect)  nxt = E_COLLECT;
      end
      E_PWAIT, E_SPWAIT: begin
        if (pcnt == PW'(1)) begin
          eng_rd = 1'b1;
          nxt    = (st == E_PWAIT) ? E_PWRITE : E_SPWRITE;
        end
      end
      E_PWRITE, E_SPWRITE: begin
        mem_we    = 1'b1;
        mem_waddr = paddr;
        mem_wdata = mem_q & pdata;
        nxt       = (st == E_PWRITE) ? E_IDLE : E_SUSP;
      end
      E_COLLECT: begin
        if (!add_sect && ecnt == EW'(1)) nxt = E_PRE;
      end
      E_PRE, E_ERASE: begin
        if (cmd_susp) begin
          nxt = E_SUSP;
        end else begin
          mem_we    = mask[walk_sec];
          mem_wdata = (st == E_PRE) ? 8'h00 : 8'hFF;
          if (walk == LAST) nxt = (st == E_PRE) ? E_ERASE : E_IDLE;
        end
      end
      E_SUSP: begin
        if (cmd_resume) nxt = phase;
        else if (cmd_prog && !prot[cmd_sec] && !mask[cmd_sec]) nxt = E_SPWAIT;
      end
      default: nxt = E_IDLE;
    endcase
  end

  assign busy     = (st != E_IDLE) && (st != E_SUSP);
  assign nxt_busy = (nxt != E_IDLE) && (nxt != E_SUSP);
  assign stat_d7  = (st == E_PWAIT || st == E_PWRITE || st == E_SPWAIT || st == E_SPWRITE)
                    ? ~pdata[7] : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= E_IDLE;
      phase <= E_PRE;
      ready <= 1'b1;
      pcnt  <= '0;
      ecnt  <= '0;
      walk  <= '0;
      paddr <= '0;
      pdata <= 8'hFF;
      mask  <= '0;
    end else begin
      st    <= nxt;
      ready <= ~nxt_busy;
      case (st)
        E_IDLE, E_SUSP: begin
          if (cmd_prog) begin
            paddr <= addr;
            pdata <= wdata;
            pcnt  <= PW'(PROG_WAIT);
          end
          if (st == E_IDLE && cmd_chip) begin
            mask <= ~prot;
            ecnt <= EW'(ERASE_WAIT);
          end else if (st == E_IDLE && cmd_sect) begin
            mask <= cmd_oh & ~prot;
            ecnt <= EW'(ERASE_WAIT);
          end
        end
        E_PWAIT, E_SPWAIT: pcnt <= pcnt - PW'(1);
        E_COLLECT: begin
          walk <= '0;
          if (add_sect) begin
            mask <= mask | (cmd_oh & ~prot);
            ecnt <= EW'(ERASE_WAIT);
          end else begin
            ecnt <= ecnt - EW'(1);
          end
        end
        E_PRE, E_ERASE: begin
          if (cmd_susp) phase <= st;
          else          walk  <= walk + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assert_locked_prog_blocked_R10: assert property (@(posedge clk) disable iff (rst)
    (st == E_IDLE && cmd_prog && prot[cmd_sec]) |=> (st == E_IDLE && ready));

  assert_suspend_ready_R9: assert property (@(posedge clk) disable iff (rst)
    ((st == E_PRE || st == E_ERASE) && cmd_susp) |=> (ready && st == E_SUSP));

  assert_no_prog_into_erasing_R9: assert property (@(posedge clk) disable iff (rst)
    (st == E_SUSP && cmd_prog && !cmd_resume && mask[cmd_sec]) |=> (st == E_SUSP));

  assert_erase_finishes_R6: assert property (@(posedge clk) disable iff (rst)
    (st == E_ERASE && walk == LAST && !cmd_susp) |=> (ready && st == E_IDLE));
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int LG_BIG     = 6,
  parameter int PROG_WAIT  = 8,
  parameter int ERASE_WAIT = 16,
  localparam int ADDR_W    = LG_BIG + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              low_vdd,
  input  logic [NSECT-1:0]  prot,
  output logic [7:0]        rdata,
  output logic              ready
);
  logic              cmd_prog, cmd_chip, cmd_sect, cmd_susp, cmd_resume;
  logic              mem_we, eng_rd, busy, stat_d7;
  logic [ADDR_W-1:0] mem_waddr, eng_raddr, raddr;
  logic [7:0]        mem_wdata, mem_q;
  logic              rd_stat, rd_d7, tog;

  nor_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .low_vdd(low_vdd), .addr(addr), .wdata(wdata),
    .cmd_prog(cmd_prog), .cmd_chip(cmd_chip), .cmd_sect(cmd_sect),
    .cmd_susp(cmd_susp), .cmd_resume(cmd_resume)
  );

  nor_engine #(
    .ADDR_W(ADDR_W), .LG_BIG(LG_BIG), .PROG_WAIT(PROG_WAIT), .ERASE_WAIT(ERASE_WAIT)
  ) u_eng (
    .clk(clk), .rst(rst), .wr_en(wr_en), .low_vdd(low_vdd), .addr(addr), .wdata(wdata),
    .prot(prot), .cmd_prog(cmd_prog), .cmd_chip(cmd_chip), .cmd_sect(cmd_sect),
    .cmd_susp(cmd_susp), .cmd_resume(cmd_resume), .mem_q(mem_q),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .eng_rd(eng_rd), .eng_raddr(eng_raddr), .busy(busy), .ready(ready), .stat_d7(stat_d7)
  );

  assign raddr = eng_rd ? eng_raddr : addr;

  nor_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata), .raddr(raddr), .q(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_stat <= 1'b0;
      rd_d7   <= 1'b0;
      tog     <= 1'b0;
    end else if (rd_en) begin
      rd_stat <= busy;
      rd_d7   <= stat_d7;
      if (busy) tog <= ~tog;
    end
  end

  assign rdata = rd_stat ? {rd_d7, tog, 6'b000000} : mem_q;

  assert_status_low_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && busy) |=> (rdata[5:0] == 6'd0));
endmodule

// File: tb/sim_nor_cmd_seq.sv
module sim_nor_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] A1 = 10'h155;
  localparam logic [9:0] A2 = 10'h2AA;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, low_vdd = 1'b0;
  logic [9:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [18:0] prot = '0;
  logic [7:0]  rdata;
  logic        ready;
  int          errs = 0, checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nor_cmd_seq u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .low_vdd(low_vdd), .prot(prot), .rdata(rdata), .ready(ready)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [9:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic unlock();
    wr(A1, 8'hAA);
    wr(A2, 8'h55);
  endtask

  task automatic wait_ready(input string tag, input int limit);
    int n = 0;
    while (!ready && n < limit) begin
      @(negedge clk);
      n++;
    end
    chk(tag, ready, 1);
  endtask

  task automatic prog4(input logic [9:0] a, input logic [7:0] d);
    unlock();
    wr(A1, 8'hA0);
    wr(a, d);
  endtask

  task automatic bp_prog(input logic [9:0] a, input logic [7:0] d);
    wr(10'h000, 8'hA0);
    wr(a, d);
    wait_ready("R4 bypass program completes", 100);
  endtask

  task automatic erase_setup();
    unlock();
    wr(A1, 8'h80);
    unlock();
  endtask

  task automatic t_reset();
    chk("R1 ready after reset", ready, 1);
    rd_chk("R1 erased array after reset", 10'h005, 8'hFF);
  endtask

  task automatic t_prog4();
    logic [7:0] s1, s2;
    prog4(10'h010, 8'h3C);
    chk("R2 busy after fourth write", ready, 0);
    rd(10'h010, s1);
    rd(10'h010, s2);
    chk("R5 busy bit7 complement", s1[7], 1);
    chk("R5 bit6 toggles", s1[6] ^ s2[6], 1);
    chk("R5 low bits zero", s2[5:0], 0);
    wait_ready("R2 program ends", 100);
    rd_chk("R2 programmed byte", 10'h010, 8'h3C);
    rd_chk("R5 true data after done", 10'h010, 8'h3C);
    prog4(10'h010, 8'hF0);
    wait_ready("R3 program ends", 100);
    rd_chk("R3 only clears bits", 10'h010, 8'h30);
  endtask

  task automatic t_unexpected();
    unlock();
    wr(A1, 8'h77);
    wr(10'h020, 8'h00);
    chk("R12 no busy after bad command", ready, 1);
    rd_chk("R12 bad command byte unchanged", 10'h020, 8'hFF);
    wr(A1, 8'hAA);
    wr(10'h123, 8'h55);
    wr(A1, 8'hA0);
    wr(10'h021, 8'h00);
    chk("R12 no busy after bad address", ready, 1);
    rd_chk("R12 bad address byte unchanged", 10'h021, 8'hFF);
  endtask

  task automatic t_lowvdd();
    low_vdd = 1'b1;
    prog4(10'h030, 8'h00);
    chk("R11 no busy under low supply", ready, 1);
    low_vdd = 1'b0;
    rd_chk("R11 byte unchanged", 10'h030, 8'hFF);
  endtask

  task automatic t_bypass();
    unlock();
    wr(A1, 8'h20);
    wr(10'h000, 8'hA0);
    wr(10'h040, 8'h5A);
    chk("R4 two-cycle program busy", ready, 0);
    wait_ready("R4 two-cycle program ends", 100);
    rd_chk("R4 two-cycle program data", 10'h040, 8'h5A);
    bp_prog(10'h041, 8'h00);
    bp_prog(10'h080, 8'h22);
    bp_prog(10'h0C0, 8'h33);
    bp_prog(10'h0C1, 8'h33);
    bp_prog(10'h3DF, 8'h11);
    bp_prog(10'h3E0, 8'h11);
    bp_prog(10'h3E7, 8'h11);
    bp_prog(10'h3E8, 8'h11);
    wr(10'h000, 8'h90);
    wr(10'h000, 8'h00);
    wr(10'h000, 8'hA0);
    wr(10'h042, 8'h00);
    chk("R4 exit leaves mode", ready, 1);
    rd_chk("R4 no program after exit", 10'h042, 8'hFF);
  endtask

  task automatic t_protect();
    prot[2] = 1'b1;
    prog4(10'h081, 8'h00);
    chk("R10 locked program not started", ready, 1);
    rd_chk("R10 locked byte unchanged", 10'h081, 8'hFF);
  endtask

  task automatic t_sector_erase();
    logic [7:0] s;
    erase_setup();
    wr(10'h040, 8'h30);
    wr(10'h080, 8'h30);
    wr(10'h3E0, 8'h30);
    chk("R6 erase busy", ready, 0);
    rd(10'h040, s);
    chk("R5 erase status bit7 zero", s[7], 0);
    wait_ready("R6 erase ends", 5000);
    rd_chk("R6 selected sector erased", 10'h040, 8'hFF);
    rd_chk("R6 selected sector erased 2", 10'h041, 8'hFF);
    rd_chk("R6 other sector untouched", 10'h0C0, 8'h33);
    rd_chk("R10 locked sector kept", 10'h080, 8'h22);
    rd_chk("R13 sector 16 low end", 10'h3E0, 8'hFF);
    rd_chk("R13 sector 16 high end", 10'h3E7, 8'hFF);
    rd_chk("R13 byte below kept", 10'h3DF, 8'h11);
    rd_chk("R13 byte above kept", 10'h3E8, 8'h11);
  endtask

  task automatic t_suspend();
    erase_setup();
    wr(10'h0C0, 8'h30);
    repeat (260) @(negedge clk);
    unlock();
    wr(A1, 8'hB0);
    chk("R9 ready after suspend", ready, 1);
    rd_chk("R8 preprogrammed to zero", 10'h0C0, 8'h00);
    rd_chk("R8 preprogrammed to zero 2", 10'h0C1, 8'h00);
    prog4(10'h100, 8'h66);
    chk("R9 program while suspended busy", ready, 0);
    wait_ready("R9 suspended program ends", 100);
    rd_chk("R9 program outside erase", 10'h100, 8'h66);
    prog4(10'h0C5, 8'h00);
    chk("R9 program inside erase ignored", ready, 1);
    unlock();
    wr(A1, 8'h30);
    chk("R9 resume busy", ready, 0);
    wait_ready("R9 resumed erase ends", 5000);
    rd_chk("R9 erase completed", 10'h0C0, 8'hFF);
    rd_chk("R9 other program kept", 10'h100, 8'h66);
  endtask

  task automatic t_chip();
    erase_setup();
    wr(A1, 8'h10);
    chk("R7 chip erase busy", ready, 0);
    wait_ready("R7 chip erase ends", 5000);
    rd_chk("R7 sector 4 erased", 10'h100, 8'hFF);
    rd_chk("R7 top sectors erased", 10'h3E8, 8'hFF);
    rd_chk("R7 low sector erased", 10'h010, 8'hFF);
    rd_chk("R10 locked sector kept in chip erase", 10'h080, 8'h22);
  endtask

  task automatic t_reset_abort();
    unlock();
    wr(A1, 8'h20);
    wr(10'h000, 8'hA0);
    wr(10'h200, 8'h00);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 ready after abort", ready, 1);
    rd_chk("R1 aborted byte unchanged", 10'h200, 8'hFF);
    wr(10'h000, 8'hA0);
    wr(10'h201, 8'h00);
    chk("R1 two-cycle mode cleared", ready, 1);
    rd_chk("R1 no program after reset", 10'h201, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_prog4();
    t_unexpected();
    t_lowvdd();
    t_bypass();
    t_protect();
    t_sector_erase();
    t_suspend();
    t_chip();
    t_reset_abort();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule